// File: doc/BRIEF.md
# Standby Power Mode Controller

This block decides when a small microcontroller core may stop working to save power, which clocks it may stop, and when the core may run again. Software writes a five-bit standby control word. The word can ask for a light nap, in which only the CPU clock is gated and peripherals keep running. It can also ask for a deep halt, in which the oscillators are switched off according to the clock source in use. The same word selects what the pins do during a halt and how long the main oscillator needs to settle afterwards.

The controller looks at interrupt requests and their two-bit urgency codes, where a lower code is more urgent. It wakes the core when a qualifying request appears. After a deep halt it holds the core until a stabilization counter expires. When the core resumes, it emits a one-cycle pulse. The pulse says either that the interrupt is to be serviced now or that execution simply continues, depending on the interrupt-enable flag and the level mask.

Top module: `stbyController`

## Requirements
- R1: A control write with bit 0 (nap request) set and no interrupt pending drops `cpuClkEn` from the second rising edge after the write. Both oscillator enables stay high during the nap.
- R2: If any peripheral or external request is pending, at any level, in the cycle of a write, the nap and halt request bits of that write are discarded. The core keeps running, and it does not enter the mode after the request goes away.
- R3: When bits 0 and 1 are both written as 1, the halt mode is entered rather than the nap.
- R4: A halt (bit 1) requested while `useSubClk` is 0 clears `mainOscEn` and keeps `subOscEn` high.
- R5: A halt requested while `useSubClk` is 1 clears both oscillator enables.
- R6: `pinHiZ` equals the pin bit (bit 2) during a halt and during the following stabilization wait. It is 0 while running or napping.
- R7: A nap ends on any peripheral or external request whose level code is numerically at most `WAKE_LEVEL`. The core runs from the next rising edge. Requests with a larger code do not end the nap.
- R8: A halt ends only on an external request whose level code is at most `WAKE_LEVEL`. Peripheral requests never end a halt.
- R9: After a halt wake edge, the core stays held for W cycles and runs from the (W+1)th rising edge. On the sub clock, W = 2^SUB_EXP. Otherwise the wait-select bits [4:3] choose W: 00 and 01 give 2^SHORT_EXP, 10 gives 2^MID_EXP, and 11 gives 2^LONG_EXP. Both oscillators are re-enabled during the wait.
- R10: In the first running cycle after any wake, exactly one of `irqService` or `resumeNext` is high, for one cycle only. `irqService` is chosen when `intEnable` is 1 and the most urgent waking level code is numerically below `ilMask`.
- R11: Reset returns the controller to running with all control bits cleared and all enables high. Any stabilization count in progress is abandoned and produces no later resume pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWrEn | input | 1 | Write strobe for the standby control word |
| ctrlWrData | input | 5 | bit0 nap request, bit1 halt request, bit2 pin high-impedance, bits4:3 wait select |
| useSubClk | input | 1 | 1 when the core runs from the sub oscillator |
| irqReq | input | N_IRQ | Peripheral interrupt requests |
| irqLevel | input | 2*N_IRQ | Level code per peripheral request, source i at bits 2i+1:2i |
| extIrq | input | 1 | External interrupt request |
| extLevel | input | 2 | Level code of the external request |
| intEnable | input | 1 | Global interrupt enable flag |
| ilMask | input | 2 | Current interrupt level mask |
| cpuClkEn | output | 1 | CPU clock enable |
| mainOscEn | output | 1 | Main oscillator enable |
| subOscEn | output | 1 | Sub oscillator enable |
| pinHiZ | output | 1 | Drive pins to high impedance |
| irqService | output | 1 | One-cycle pulse: resume into interrupt service |
| resumeNext | output | 1 | One-cycle pulse: resume at the next instruction |

## Verification
The hardest situation to reach from the ports is a reset that lands part-way through the post-halt stabilization wait. The wait only exists after a halt entry that was not refused and a qualifying external wake, so the stimulus has to build that sequence first. The bench then pulls reset a few cycles into the count and watches the resume pulses for longer than the longest wait, to make sure none appears. To keep the waits short, the bench shrinks the exponents through parameters. It then measures every wait-select code and the sub-clock case edge by edge.

// File: rtl/stbyPkg.sv
package stbyPkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_NAP   = 2'd1,
    MODE_HALT  = 2'd2,
    MODE_SETTLE = 2'd3
  } modeE;

  // control -> datapath
  typedef struct packed {
    logic clrReq;
    logic loadCnt;
    logic tickCnt;
    logic grabExt;
    logic resumeLive;
    logic resumeHeld;
  } dpStrobeS;

  // datapath -> control
  typedef struct packed {
    logic reqNap;
    logic reqHalt;
    logic napWake;
    logic haltWake;
    logic cntZero;
  } dpStatusS;

endpackage

// File: rtl/stbyDatapath.sv
module stbyDatapath
  import stbyPkg::*;
#(
  parameter int          N_IRQ      = 8,
  parameter logic [1:0]  WAKE_LEVEL = 2'b11,
  parameter int          SHORT_EXP  = 14,
  parameter int          MID_EXP    = 17,
  parameter int          LONG_EXP   = 18,
  parameter int          SUB_EXP    = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWrEn,
  input  logic [4:0]         ctrlWrData,
  input  logic               useSubClk,
  input  logic [N_IRQ-1:0]   irqReq,
  input  logic [2*N_IRQ-1:0] irqLevel,
  input  logic               extIrq,
  input  logic [1:0]         extLevel,
  input  logic               intEnable,
  input  logic [1:0]         ilMask,
  input  dpStrobeS           strobe,
  output dpStatusS           status,
  output logic               pinBit,
  output logic               subLatched,
  output logic               irqService,
  output logic               resumeNext
);

  localparam int MAX_A   = (SHORT_EXP > MID_EXP) ? SHORT_EXP : MID_EXP;
  localparam int MAX_B   = (LONG_EXP > SUB_EXP) ? LONG_EXP : SUB_EXP;
  localparam int MAX_EXP = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = MAX_EXP + 1;

  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] LD_SHORT = (ONE << SHORT_EXP) - ONE;
  localparam logic [CNT_W-1:0] LD_MID   = (ONE << MID_EXP) - ONE;
  localparam logic [CNT_W-1:0] LD_LONG  = (ONE << LONG_EXP) - ONE;
  localparam logic [CNT_W-1:0] LD_SUB   = (ONE << SUB_EXP) - ONE;

  logic             napQ, haltQ, pinQ, subQ;
  logic [1:0]       waitSelQ;
  logic [CNT_W-1:0] cntQ;
  logic [1:0]       heldLvlQ;
  logic             svcQ, nextQ;

  logic             anyPending;
  logic [N_IRQ-1:0] periphQual;
  logic             extQual;
  logic             anyQual;
  logic [1:0]       bestLvl;
  logic [CNT_W-1:0] loadVal;
  logic             liveAccept, heldAccept;

  assign anyPending = (|irqReq) | extIrq;
  assign extQual    = extIrq && (extLevel <= WAKE_LEVEL);

  for (genvar g = 0; g < N_IRQ; g++) begin : gQual
    assign periphQual[g] = irqReq[g] && (irqLevel[2*g +: 2] <= WAKE_LEVEL);
  end

  // most urgent (lowest code) among qualifying wake sources
  always_comb begin
    anyQual = extQual;
    bestLvl = extLevel;
    for (int i = 0; i < N_IRQ; i++) begin
      if (periphQual[i] && (!anyQual || (irqLevel[2*i +: 2] < bestLvl))) begin
        anyQual = 1'b1;
        bestLvl = irqLevel[2*i +: 2];
      end
    end
  end

  always_comb begin
    if (subQ) begin
      loadVal = LD_SUB;
    end else begin
      unique case (waitSelQ)
        2'b10:   loadVal = LD_MID;
        2'b11:   loadVal = LD_LONG;
        default: loadVal = LD_SHORT;
      endcase
    end
  end

  assign liveAccept = intEnable && (bestLvl < ilMask);
  assign heldAccept = intEnable && (heldLvlQ < ilMask);

  // standby control word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      napQ     <= 1'b0;
      haltQ    <= 1'b0;
      pinQ     <= 1'b0;
      subQ     <= 1'b0;
      waitSelQ <= 2'b00;
    end else if (strobe.clrReq) begin
      napQ  <= 1'b0;
      haltQ <= 1'b0;
    end else if (ctrlWrEn) begin
      pinQ     <= ctrlWrData[2];
      waitSelQ <= ctrlWrData[4:3];
      if (!anyPending && (ctrlWrData[0] || ctrlWrData[1])) begin
        haltQ <= ctrlWrData[1];
        napQ  <= ctrlWrData[0] && !ctrlWrData[1];
        subQ  <= useSubClk;
      end
    end
  end

  // stabilization counter and captured wake level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ     <= '0;
      heldLvlQ <= 2'b11;
    end else begin
      if (strobe.loadCnt)      cntQ <= loadVal;
      else if (strobe.tickCnt) cntQ <= cntQ - ONE;
      if (strobe.grabExt)      heldLvlQ <= extLevel;
    end
  end

  // resume pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcQ  <= 1'b0;
      nextQ <= 1'b0;
    end else if (strobe.resumeLive) begin
      svcQ  <= liveAccept;
      nextQ <= !liveAccept;
    end else if (strobe.resumeHeld) begin
      svcQ  <= heldAccept;
      nextQ <= !heldAccept;
    end else begin
      svcQ  <= 1'b0;
      nextQ <= 1'b0;
    end
  end

  assign status.reqNap   = napQ;
  assign status.reqHalt  = haltQ;
  assign status.napWake  = anyQual;
  assign status.haltWake = extQual;
  assign status.cntZero  = (cntQ == '0);

  assign pinBit     = pinQ;
  assign subLatched = subQ;
  assign irqService = svcQ;
  assign resumeNext = nextQ;

endmodule

// File: rtl/stbyControl.sv
module stbyControl
  import stbyPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  dpStatusS status,
  input  logic     pinBit,
  input  logic     subLatched,
  output dpStrobeS strobe,
  output logic     cpuClkEn,
  output logic     mainOscEn,
  output logic     subOscEn,
  output logic     pinHiZ
);

  modeE modeQ, modeD;

  always_comb begin
    modeD  = modeQ;
    strobe = '0;
    unique case (modeQ)
      MODE_RUN: begin
        if (status.reqHalt)     modeD = MODE_HALT;
        else if (status.reqNap) modeD = MODE_NAP;
      end
      MODE_NAP: begin
        if (status.napWake) begin
          modeD             = MODE_RUN;
          strobe.clrReq     = 1'b1;
          strobe.resumeLive = 1'b1;
        end
      end
      MODE_HALT: begin
        if (status.haltWake) begin
          modeD          = MODE_SETTLE;
          strobe.loadCnt = 1'b1;
          strobe.grabExt = 1'b1;
        end
      end
      MODE_SETTLE: begin
        if (status.cntZero) begin
          modeD             = MODE_RUN;
          strobe.clrReq     = 1'b1;
          strobe.resumeHeld = 1'b1;
        end else begin
          strobe.tickCnt = 1'b1;
        end
      end
      default: modeD = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_RUN;
    else       modeQ <= modeD;
  end

  assign cpuClkEn  = (modeQ == MODE_RUN);
  assign mainOscEn = (modeQ != MODE_HALT);
  assign subOscEn  = !((modeQ == MODE_HALT) && subLatched);
  assign pinHiZ    = pinBit && ((modeQ == MODE_HALT) || (modeQ == MODE_SETTLE));

endmodule

// File: rtl/stbyController.sv
module stbyController
  import stbyPkg::*;
#(
  parameter int          N_IRQ      = 8,
  parameter logic [1:0]  WAKE_LEVEL = 2'b11,
  parameter int          SHORT_EXP  = 14,
  parameter int          MID_EXP    = 17,
  parameter int          LONG_EXP   = 18,
  parameter int          SUB_EXP    = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWrEn,
  input  logic [4:0]         ctrlWrData,
  input  logic               useSubClk,
  input  logic [N_IRQ-1:0]   irqReq,
  input  logic [2*N_IRQ-1:0] irqLevel,
  input  logic               extIrq,
  input  logic [1:0]         extLevel,
  input  logic               intEnable,
  input  logic [1:0]         ilMask,
  output logic               cpuClkEn,
  output logic               mainOscEn,
  output logic               subOscEn,
  output logic               pinHiZ,
  output logic               irqService,
  output logic               resumeNext
);

  dpStrobeS strobe;
  dpStatusS status;
  logic     pinBit;
  logic     subLatched;

  stbyDatapath #(
    .N_IRQ(N_IRQ), .WAKE_LEVEL(WAKE_LEVEL), .SHORT_EXP(SHORT_EXP),
    .MID_EXP(MID_EXP), .LONG_EXP(LONG_EXP), .SUB_EXP(SUB_EXP)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .useSubClk(useSubClk), .irqReq(irqReq), .irqLevel(irqLevel),
    .extIrq(extIrq), .extLevel(extLevel), .intEnable(intEnable),
    .ilMask(ilMask), .strobe(strobe), .status(status), .pinBit(pinBit),
    .subLatched(subLatched), .irqService(irqService), .resumeNext(resumeNext)
  );

  stbyControl ctl_i (
    .clk(clk), .rstN(rstN), .status(status), .pinBit(pinBit),
    .subLatched(subLatched), .strobe(strobe), .cpuClkEn(cpuClkEn),
    .mainOscEn(mainOscEn), .subOscEn(subOscEn), .pinHiZ(pinHiZ)
  );

endmodule

// File: rtl/stbyChecker.sv
module stbyChecker #(
  parameter int N_IRQ = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlWrEn,
  input logic [N_IRQ-1:0] irqReq,
  input logic             extIrq,
  input logic             cpuClkEn,
  input logic             mainOscEn,
  input logic             subOscEn,
  input logic             irqService,
  input logic             resumeNext
);

  logic pendingAny;
  assign pendingAny = (|irqReq) | extIrq;

  // R2: a write made while something is pending cannot stop the core
  a_r2_refuse_entry: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && ctrlWrEn && pendingAny && !$past(ctrlWrEn)) |=> ##1 cpuClkEn);

  // R4 / R5: sub oscillator only ever off together with the main one
  a_r5_sub_implies_main: assert property (@(posedge clk) disable iff (!rstN)
    !subOscEn |-> !mainOscEn);

  // R4: main oscillator off means the CPU clock is off
  a_r4_main_off_cpu_off: assert property (@(posedge clk) disable iff (!rstN)
    !mainOscEn |-> !cpuClkEn);

  // R8: without an external request a halt persists
  a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!mainOscEn && !extIrq) |=> !cpuClkEn);

  // R10: pulses last one cycle, are exclusive, and occur while running
  a_r10_svc_single: assert property (@(posedge clk) disable iff (!rstN)
    irqService |=> !irqService);
  a_r10_next_single: assert property (@(posedge clk) disable iff (!rstN)
    resumeNext |=> !resumeNext);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(irqService && resumeNext));
  a_r10_pulse_running: assert property (@(posedge clk) disable iff (!rstN)
    (irqService || resumeNext) |-> cpuClkEn);

endmodule

bind stbyController stbyChecker #(.N_IRQ(N_IRQ)) chk_i (
  .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .irqReq(irqReq),
  .extIrq(extIrq), .cpuClkEn(cpuClkEn), .mainOscEn(mainOscEn),
  .subOscEn(subOscEn), .irqService(irqService), .resumeNext(resumeNext)
);

// File: tb/stbyController_tb.sv
module stbyController_tb_top;

  localparam int N_IRQ = 4;
  localparam int SE = 3, ME = 5, LE = 6, BE = 4;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               ctrlWrEn = 1'b0;
  logic [4:0]         ctrlWrData = '0;
  logic               useSubClk = 1'b0;
  logic [N_IRQ-1:0]   irqReq = '0;
  logic [2*N_IRQ-1:0] irqLevel = '0;
  logic               extIrq = 1'b0;
  logic [1:0]         extLevel = '0;
  logic               intEnable = 1'b0;
  logic [1:0]         ilMask = '0;
  logic cpuClkEn, mainOscEn, subOscEn, pinHiZ, irqService, resumeNext;

  int runCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  stbyController #(
    .N_IRQ(N_IRQ), .WAKE_LEVEL(2'b10), .SHORT_EXP(SE), .MID_EXP(ME),
    .LONG_EXP(LE), .SUB_EXP(BE)
  ) dut_i (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .useSubClk(useSubClk), .irqReq(irqReq), .irqLevel(irqLevel),
    .extIrq(extIrq), .extLevel(extLevel), .intEnable(intEnable),
    .ilMask(ilMask), .cpuClkEn(cpuClkEn), .mainOscEn(mainOscEn),
    .subOscEn(subOscEn), .pinHiZ(pinHiZ), .irqService(irqService),
    .resumeNext(resumeNext)
  );

  // {useSub, pendPeriph, pendExt, wrData[4:0], expClk, expMain, expSub, expHiZ}
  localparam logic [11:0] VEC [8] = '{
    {3'b000, 5'b00001, 4'b0110},  // R1 nap
    {3'b000, 5'b00010, 4'b0010},  // R4 halt on main
    {3'b000, 5'b00110, 4'b0011},  // R6 halt, pins high-Z
    {3'b100, 5'b00010, 4'b0000},  // R5 halt on sub
    {3'b000, 5'b00011, 4'b0010},  // R3 both bits, halt wins
    {3'b010, 5'b00001, 4'b1110},  // R2 nap refused
    {3'b001, 5'b00010, 4'b1110},  // R2 halt refused
    {3'b000, 5'b00101, 4'b0110}   // R6 nap keeps pins driven
  };

  function automatic string vecTag(int i);
    case (i)
      0: return "R1";
      1: return "R4";
      2: return "R6";
      3: return "R5";
      4: return "R3";
      5: return "R2";
      6: return "R2";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    ctrlWrEn = 1'b0; irqReq = '0; extIrq = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeCtrl(logic [4:0] d);
    ctrlWrData = d;
    ctrlWrEn = 1'b1;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  // enter halt, wake with external level 0, measure cycles to run
  task automatic haltWait(logic sub, logic [1:0] ws, int w, string tag);
    int k;
    useSubClk = sub;
    writeCtrl({ws, 3'b010});
    @(negedge clk);
    check(tag, cpuClkEn, 0, "halt entered");
    extLevel = 2'b00; intEnable = 1'b1; ilMask = 2'b01;
    extIrq = 1'b1;
    k = 0;
    while (k < 500) begin
      @(negedge clk);
      k++;
      if (cpuClkEn) break;
    end
    check(tag, k, w + 1, "edges from wake to run");
    check("R10", irqService, 1, "service pulse after settle");
    extIrq = 1'b0;
    @(negedge clk);
    useSubClk = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int seen;
    doReset();
    // R11 reset state
    check("R11", {cpuClkEn, mainOscEn, subOscEn, pinHiZ, irqService, resumeNext},
          6'b111000, "reset outputs");

    // entry table
    foreach (VEC[i]) begin
      doReset();
      useSubClk = VEC[i][11];
      irqReq    = {3'b000, VEC[i][10]};
      irqLevel  = 8'hFF;
      extLevel  = 2'b11;
      extIrq    = VEC[i][9];
      writeCtrl(VEC[i][8:4]);
      irqReq = '0; extIrq = 1'b0; useSubClk = 1'b0;
      repeat (4) @(negedge clk);
      check(vecTag(i), {cpuClkEn, mainOscEn, subOscEn, pinHiZ}, VEC[i][3:0],
            "mode outputs after write");
    end

    // R7 nap wake filtering and R10 accept
    doReset();
    writeCtrl(5'b00001);
    @(negedge clk);
    irqLevel = {2'b00, 2'b01, 2'b11, 2'b00};
    irqReq = 4'b0010;                 // level 3, above WAKE_LEVEL
    repeat (3) @(negedge clk);
    check("R7", cpuClkEn, 0, "nap held by non-qualifying level");
    intEnable = 1'b1; ilMask = 2'b10;
    irqReq = 4'b0110;                 // add level 1
    @(negedge clk);
    check("R7", cpuClkEn, 1, "nap ended by level 1");
    check("R10", {irqService, resumeNext}, 2'b10, "accepted wake");
    irqReq = '0;
    @(negedge clk);
    check("R10", {irqService, resumeNext}, 2'b00, "pulse one cycle");

    // R10 not accepted: external level 2 against mask 2
    writeCtrl(5'b00001);
    @(negedge clk);
    extLevel = 2'b10; extIrq = 1'b1;
    @(negedge clk);
    check("R10", {cpuClkEn, irqService, resumeNext}, 3'b101, "resume at next instruction");
    extIrq = 1'b0;
    @(negedge clk);

    // R8 halt ignores peripherals and weak external
    writeCtrl(5'b00010);
    @(negedge clk);
    irqLevel = '0; irqReq = 4'b1111;
    repeat (4) @(negedge clk);
    check("R8", {cpuClkEn, mainOscEn}, 2'b00, "peripheral cannot wake halt");
    irqReq = '0;
    extLevel = 2'b11; extIrq = 1'b1;
    repeat (4) @(negedge clk);
    check("R8", {cpuClkEn, mainOscEn}, 2'b00, "level 3 external cannot wake halt");
    extLevel = 2'b00;
    @(negedge clk);
    check("R9", {cpuClkEn, mainOscEn, subOscEn}, 3'b011, "oscillators on while settling");
    extIrq = 1'b0;
    repeat (12) @(negedge clk);

    // R9 wait lengths
    haltWait(1'b0, 2'b00, 1 << SE, "R9");
    haltWait(1'b0, 2'b01, 1 << SE, "R9");
    haltWait(1'b0, 2'b10, 1 << ME, "R9");
    haltWait(1'b0, 2'b11, 1 << LE, "R9");
    haltWait(1'b1, 2'b11, 1 << BE, "R9");

    // R6 pins high-Z while settling
    writeCtrl(5'b00110);
    @(negedge clk);
    extLevel = 2'b00; extIrq = 1'b1;
    @(negedge clk);
    check("R6", pinHiZ, 1, "high-Z during settle");
    extIrq = 1'b0;
    repeat (12) @(negedge clk);
    check("R6", pinHiZ, 0, "pins driven after resume");

    // R11 reset aborts a settle count
    writeCtrl(5'b11110);
    @(negedge clk);
    extIrq = 1'b1;
    repeat (5) @(negedge clk);
    extIrq = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R11", {cpuClkEn, mainOscEn, subOscEn, pinHiZ}, 4'b1110, "reset mid-settle");
    seen = 0;
    repeat (100) begin
      @(negedge clk);
      if (irqService || resumeNext) seen++;
    end
    check("R11", seen, 0, "no resume pulse after abort");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule